// File: doc/BRIEF.md
# Message-Signalled Interrupt Requester

This block converts a device's internal interrupt lines into message-signalled interrupts. Each interrupt leaves the block as one memory write request. The request carries an address and a data word that software has programmed. The block holds the programmed state: a message address, a message data word, a global enable bit, the size of the vector allocation as a power of two, and a mask bit for every vector. It also keeps one pending bit for each vector, and these bits are visible at a port.

The source lines are edge-triggered, and each line owns one vector. A rising edge on an allocated source marks that vector pending. The block then issues a pending vector when it is unmasked and the block is enabled. The vector number goes into the low bits of the data word. A vector that fires while masked or disabled stays pending and goes out once it is allowed. Requests leave one at a time on a valid/ready channel, the lowest index first.

Top module: `msi_requester`

## Requirements
- R1: A request's address is the programmed address with bits [1:0] forced to zero. Its data is the programmed data with the low k bits replaced by the vector index, where 2^k vectors are allocated.
- R2: Configuration writes use cfg_sel. Code 0 writes address bits [31:2]. Code 1 writes address bits [ADDR_W-1:32]. Code 2 writes the data word. Code 3 writes enable in bit 0 and k in bits [6:4]; a k above log2(NUM_VEC) is stored as log2(NUM_VEC). Code 4 writes the mask, where bit n masks vector n. After reset, every field is zero.
- R3: A rising edge on src_i[n] with n < 2^k sets pend_o[n]. A level held high yields one message, and a falling edge yields none.
- R4: Edges on sources at or above the allocation are ignored. Their pend_o bits stay 0 and no request is issued for them.
- R5: A masked vector that fires keeps its pending bit set and issues no request. Clearing its mask issues the request.
- R6: While enable is 0, no new request is launched and source edges are still recorded as pending. Setting enable releases them.
- R7: When several vectors are eligible, they are issued lowest index first, one write per valid/ready handshake.
- R8: Further edges on a vector whose message has not yet been accepted merge into that single message.
- R9: Once req_valid is high, it stays high with req_addr and req_data unchanged until req_ready is seen.
- R10: pend_o[n] clears on the clock edge where the request for vector n is accepted.
- R11: After reset, req_valid is 0 and pend_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_VEC | Interrupt source lines, one per vector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Write request accepted by the fabric |
| req_addr | output | ADDR_W | Write address |
| req_data | output | DATA_W | Write data |
| pend_o | output | NUM_VEC | Pending bit per vector |

## Verification
The bench builds the block with NUM_VEC = 8, ADDR_W = 64 and DATA_W = 16. That keeps the sweep small enough to be exhaustive: every allocation size k from 0 to 3 is paired with every one of the eight source lines. This checks the data encoding for each vector inside the allocation and confirms that vectors outside it are ignored. With only eight vectors, the clamp of an oversized k value (7 becomes 3) can also be checked. The same small size lets the bench test mask release, the disable window, merge and ordering with exact expected pending patterns.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // Configuration field select codes
  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_DATA    = 3'd2,
    SEL_CTRL    = 3'd3,
    SEL_MASK    = 3'd4
  } cfg_sel_e;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_K_LSB  = 4;
  localparam int CTRL_K_W    = 3;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 16,
  parameter int KW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               en_q,
  output logic [KW-1:0]      k_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DATA_W-1:0]  data_q,
  output logic [NUM_VEC-1:0] mask_q
);
  localparam int LOG2 = $clog2(NUM_VEC);
  localparam int HI_W = ADDR_W - 32;

  logic [31:0]        lo_q, lo_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [DATA_W-1:0]  data_d;
  logic [NUM_VEC-1:0] mask_d;
  logic               en_d;
  logic [KW-1:0]      k_d;
  logic               we_lo, we_hi, we_data, we_ctrl, we_mask;
  logic [CTRL_K_W-1:0] k_raw;

  always_comb begin
    we_lo   = cfg_we && (cfg_sel == SEL_ADDR_LO);
    we_hi   = cfg_we && (cfg_sel == SEL_ADDR_HI);
    we_data = cfg_we && (cfg_sel == SEL_DATA);
    we_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
    we_mask = cfg_we && (cfg_sel == SEL_MASK);
    k_raw   = cfg_wdata[CTRL_K_LSB +: CTRL_K_W];
    lo_d    = {cfg_wdata[31:2], 2'b00};
    hi_d    = cfg_wdata[HI_W-1:0];
    data_d  = cfg_wdata[DATA_W-1:0];
    mask_d  = cfg_wdata[NUM_VEC-1:0];
    en_d    = cfg_wdata[CTRL_EN_BIT];
    if (int'(k_raw) > LOG2) k_d = KW'(LOG2);
    else                    k_d = KW'(k_raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      data_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      k_q    <= '0;
    end else begin
      if (we_lo)   lo_q   <= lo_d;
      if (we_hi)   hi_q   <= hi_d;
      if (we_data) data_q <= data_d;
      if (we_mask) mask_q <= mask_d;
      if (we_ctrl) begin
        en_q <= en_d;
        k_q  <= k_d;
      end
    end
  end

  assign addr_q = {hi_q, lo_q};
endmodule

// File: rtl/msi_vec_state.sv
module msi_vec_state #(
  parameter int NUM_VEC = 32,
  parameter int KW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] src_i,
  input  logic [KW-1:0]      k_q,
  input  logic [NUM_VEC-1:0] clr_oh,
  output logic [NUM_VEC-1:0] alloc,
  output logic [NUM_VEC-1:0] pend_q
);
  logic [NUM_VEC-1:0] src_q;
  logic [NUM_VEC-1:0] rise;
  logic [NUM_VEC-1:0] pend_d;

  for (genvar n = 0; n < NUM_VEC; n++) begin : g_vec
    // vector n belongs to the allocation when n < 2^k
    assign alloc[n]  = ((32'(n) >> k_q) == 32'd0);
    assign rise[n]   = src_i[n] & ~src_q[n] & alloc[n];
    // a fresh edge wins over a clear in the same cycle
    assign pend_d[n] = (pend_q[n] & ~clr_oh[n]) | rise[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
  parameter int NUM_VEC = 32,
  parameter int IW      = 5
) (
  input  logic [NUM_VEC-1:0] cand,
  output logic               found,
  output logic [IW-1:0]      idx,
  output logic [NUM_VEC-1:0] onehot
);
  always_comb begin
    found  = |cand;
    onehot = cand & (~cand + NUM_VEC'(1));
    idx    = '0;
    for (int n = NUM_VEC - 1; n >= 0; n--) begin
      if (cand[n]) idx = IW'(n);
    end
  end
endmodule

// File: rtl/msi_requester.sv
module msi_requester #(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] src_i,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_data,
  output logic [NUM_VEC-1:0] pend_o
);
  localparam int LOG2 = $clog2(NUM_VEC);
  localparam int KW   = (LOG2 > 0) ? $clog2(LOG2 + 1) : 1;
  localparam int IW   = (LOG2 > 0) ? LOG2 : 1;

  logic               en_q;
  logic [KW-1:0]      k_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [NUM_VEC-1:0] mask_q;
  logic [NUM_VEC-1:0] alloc;
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] clr_oh;
  logic [NUM_VEC-1:0] cand;
  logic [NUM_VEC-1:0] sel_oh;
  logic [NUM_VEC-1:0] fly_oh;
  logic [IW-1:0]      sel_idx;
  logic               found;
  logic               accept;
  logic               launch;
  logic               valid_d;
  logic [DATA_W-1:0]  low_m;
  logic [DATA_W-1:0]  msg_d;
  logic [NUM_VEC-1:0] vec_oh_q;

  msi_cfg_regs #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KW(KW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_q(en_q), .k_q(k_q), .addr_q(addr_q),
    .data_q(data_q), .mask_q(mask_q)
  );

  msi_vec_state #(.NUM_VEC(NUM_VEC), .KW(KW)) u_vec (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .k_q(k_q),
    .clr_oh(clr_oh), .alloc(alloc), .pend_q(pend_q)
  );

  msi_pick #(.NUM_VEC(NUM_VEC), .IW(IW)) u_pick (
    .cand(cand), .found(found), .idx(sel_idx), .onehot(sel_oh)
  );

  // next-state logic for the request register
  always_comb begin
    accept  = req_valid & req_ready;
    fly_oh  = req_valid ? vec_oh_q : '0;
    clr_oh  = accept ? vec_oh_q : '0;
    // the vector in flight is never picked again until its pending bit is rebuilt
    cand    = pend_q & ~mask_q & alloc & {NUM_VEC{en_q}} & ~fly_oh;
    launch  = found & (~req_valid | accept);
    valid_d = launch | (req_valid & ~accept);
    low_m   = (DATA_W'(1) << k_q) - DATA_W'(1);
    msg_d   = (data_q & ~low_m) | DATA_W'(sel_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
      vec_oh_q  <= '0;
    end else begin
      req_valid <= valid_d;
      if (launch) begin
        req_addr <= addr_q;
        req_data <= msg_d;
        vec_oh_q <= sel_oh;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/msi_requester_chk.sv
module msi_requester_chk #(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_data,
  input logic               en_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] cand,
  input logic [NUM_VEC-1:0] sel_oh,
  input logic               launch
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> en_q);

  p_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (((sel_oh & mask_q) == '0) && ((sel_oh & pend_q) == sel_oh)));

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ($onehot(sel_oh) && (((sel_oh - NUM_VEC'(1)) & cand) == '0)));

  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));
endmodule

bind msi_requester msi_requester_chk #(
  .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .en_q(en_q), .mask_q(mask_q),
  .pend_q(pend_q), .cand(cand), .sel_oh(sel_oh), .launch(launch)
);

// File: tb/test_msi_requester.sv
module test_msi_requester;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int AW = 64;
  localparam int DW = 16;
  localparam logic [31:0] A_LO = 32'h9ABC_DEF3;
  localparam logic [31:0] A_HI = 32'h1234_5678;
  localparam logic [AW-1:0] EXP_ADDR = 64'h1234_5678_9ABC_DEF0;
  localparam logic [DW-1:0] DAT = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NV-1:0] src_i;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [NV-1:0] pend_o;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msi_requester #(.NUM_VEC(NV), .ADDR_W(AW), .DATA_W(DW)) i_msi_requester (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .pend_o(pend_o)
  );

  function automatic logic [DW-1:0] exp_data(int k, int n);
    logic [DW-1:0] m;
    m = (DW'(1) << k) - DW'(1);
    return (DAT & ~m) | DW'(n);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [2:0] sel, logic [31:0] wd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); src_i[n] = 1'b1;
    @(negedge clk); src_i[n] = 1'b0;
  endtask

  // waits up to max cycles for an accepted request (ready must be 1)
  task automatic wait_msg(int max, output bit got, output logic [AW-1:0] a,
                          output logic [DW-1:0] d);
    got = 1'b0; a = '0; d = '0;
    for (int i = 0; i < max && !got; i++) begin
      if (req_valid && req_ready) begin
        got = 1'b1; a = req_addr; d = req_data;
      end
      @(negedge clk);
    end
  endtask

  task automatic count_msgs(int window, output int cnt);
    cnt = 0;
    for (int i = 0; i < window; i++) begin
      if (req_valid && req_ready) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit got;
    logic [AW-1:0] a, a0;
    logic [DW-1:0] d, d0;
    int c;
    rst_n = 1'b0; src_i = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_valid == 1'b0, "R11 valid after reset", req_valid, 0);
    check(pend_o == '0, "R11 pend after reset", pend_o, 0);
    // R2 enable is 0 after reset: an edge is only recorded
    pulse(0);
    count_msgs(5, c);
    check(c == 0, "R2 reset enable off", c, 0);
    check(pend_o == 8'h01, "R2 reset k=0 records vector 0", pend_o, 8'h01);

    cfg_wr(3'd0, A_LO);
    cfg_wr(3'd1, A_HI);
    cfg_wr(3'd2, 32'(DAT));
    cfg_wr(3'd3, 32'h01);
    wait_msg(8, got, a, d);
    check(got && d == exp_data(0, 0), "R6 release on enable", d, exp_data(0, 0));

    // R1 R3 R4 exhaustive sweep over allocation size and source index
    for (int k = 0; k <= 3; k++) begin
      cfg_wr(3'd3, 32'((k << 4) | 1));
      for (int n = 0; n < NV; n++) begin
        pulse(n);
        wait_msg(8, got, a, d);
        if (n < (1 << k)) begin
          check(got, "R3 message issued", got, 1);
          check(d == exp_data(k, n), "R1 data", d, exp_data(k, n));
          check(a == EXP_ADDR, "R1 addr", a, EXP_ADDR);
        end else begin
          check(!got, "R4 unallocated ignored", got, 0);
          check(pend_o == '0, "R4 pend stays clear", pend_o, 0);
        end
      end
    end

    // R3 level held high gives one message, falling edge none
    cfg_wr(3'd3, 32'h31);
    @(negedge clk); src_i[4] = 1'b1;
    count_msgs(12, c);
    check(c == 1, "R3 level held", c, 1);
    src_i[4] = 1'b0;
    count_msgs(6, c);
    check(c == 0, "R3 falling edge", c, 0);

    // R5 mask holds the vector pending; R10 clears on accept
    cfg_wr(3'd4, 32'h08);
    pulse(3);
    count_msgs(6, c);
    check(c == 0, "R5 masked no message", c, 0);
    check(pend_o == 8'h08, "R5 masked pending", pend_o, 8'h08);
    cfg_wr(3'd4, 32'h00);
    wait_msg(8, got, a, d);
    check(got && d == exp_data(3, 3), "R5 unmask delivers", d, exp_data(3, 3));
    check(pend_o == '0, "R10 pend cleared after accept", pend_o, 0);

    // R6 disabled: record only; R7 order; R8 merge; R9 hold
    req_ready = 1'b0;
    cfg_wr(3'd3, 32'h30);
    pulse(5); pulse(2); pulse(6);
    repeat (4) @(negedge clk);
    check(!req_valid, "R6 no request while disabled", req_valid, 0);
    check(pend_o == 8'h64, "R6 pending recorded", pend_o, 8'h64);
    cfg_wr(3'd3, 32'h31);
    @(negedge clk);
    check(req_valid && req_data == exp_data(3, 2), "R7 lowest first", req_data, exp_data(3, 2));
    pulse(2);
    a0 = req_addr; d0 = req_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req_valid && req_addr == a0 && req_data == d0, "R9 hold while stalled", req_data, d0);
    end
    req_ready = 1'b1;
    wait_msg(4, got, a, d);
    check(got && d == exp_data(3, 2), "R7 first is 2", d, exp_data(3, 2));
    wait_msg(4, got, a, d);
    check(got && d == exp_data(3, 5), "R7 second is 5", d, exp_data(3, 5));
    wait_msg(4, got, a, d);
    check(got && d == exp_data(3, 6), "R7 third is 6", d, exp_data(3, 6));
    count_msgs(8, c);
    check(c == 0, "R8 no extra message for merged edge", c, 0);
    check(pend_o == '0, "R10 all pending cleared", pend_o, 0);

    // R8 two edges while disabled merge into one
    cfg_wr(3'd3, 32'h30);
    pulse(1); pulse(1);
    cfg_wr(3'd3, 32'h31);
    count_msgs(10, c);
    check(c == 1, "R8 merged while disabled", c, 1);

    // R2 k above the limit is clamped to log2(NV)=3
    cfg_wr(3'd3, 32'h71);
    pulse(7);
    wait_msg(8, got, a, d);
    check(got && d == exp_data(3, 7), "R2 k clamp", d, exp_data(3, 7));

    summary();
    $finish;
  end
endmodule